// File: doc/BRIEF.md
# Serial EEPROM Slave with Write-Cancel Window

This block is a two-wire serial EEPROM slave built for synthesis. It oversamples SCL and SDA on the system clock and finds START and STOP conditions. It decodes a device address byte, a word address byte and data bytes, and it pulls SDA low through an open-drain enable to acknowledge. Data bytes of a write are collected in a page buffer. After STOP, a timed internal write cycle runs, and the buffer is copied into the byte array only when that cycle finishes. Reads are supported in two forms: random reads (a dummy write of the word address, then a repeated START) and current-address reads.

The write-protect input does not gate address decoding. Its level is ignored until the SCL rise that latches the last bit of the first data byte. From that edge until the internal write cycle ends, a high level cancels the write and the slave returns to standby at once:
- If the cycle has not started yet, the array is left untouched.
- If the cycle is already running, it is cut short and the locations being written are left holding a defined corrupt marker.

Top module: `i2c_eeprom_wp`

## Requirements
- R1: After reset the slave does not drive SDA, and every array location reads back as 8'h00.
- R2: A device address byte whose upper seven bits equal DEV_ADDR (default 7'b1010000, bit 0 being read=1/write=0) is acknowledged. Any other device address is not acknowledged.
- R3: A write of device address, word address, one data byte and STOP with the write-protect input low stores that byte, and a later read of that address returns it.
- R4: Successive data bytes of one write go to successive addresses. Only the low log2(PAGE_SIZE) address bits increment, so a write that crosses the page end wraps to the start of the same page, and later bytes overwrite earlier ones.
- R5: While the internal write cycle (WR_CYCLES clocks, started by STOP) is running, the device address is not acknowledged. Once the cycle is over, the address is acknowledged again.
- R6: Write-protect high at any time from START up to (but not at) the SCL rise that latches bit D0 of the first data byte has no effect: the write completes normally.
- R7: Write-protect high at the SCL rise that latches D0 of the first data byte cancels the write. That byte is not acknowledged, no location changes, and the next device address is acknowledged with no write-cycle wait.
- R8: Write-protect rising after the first data byte's D0 edge but before STOP cancels the whole write. Bytes that follow are not acknowledged and no location changes.
- R9: Write-protect rising during the internal write cycle stops it at once. Every location loaded by that write then reads 8'hFF, and the next device address is acknowledged without waiting for the remaining cycle time.
- R10: A read returns the array byte at the internal address pointer and then advances the pointer by one across the whole array, so a current-address read returns the next location. A random read sets the pointer through a word address followed by a repeated START.
- R11: A STOP after the word address with no data byte starts no write cycle: the next device address is acknowledged at once and the addressed location is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the bus master |
| sda_i | input | 1 | Resolved level of the SDA line |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain drive) |
| wp_i | input | 1 | Write-protect / write-cancel level |

## Verification
The assertions assume the following about the inputs:
- SCL and SDA change slowly compared with the system clock, so the synchroniser delays both equally.
- SDA changes only while SCL is low, except at START and STOP.
- A STOP never lands in the same cycle as a completed data byte.

The bench drives the bus from tasks that hold each quarter of an SCL period for four clocks. It moves SDA only in the low phase of SCL, and it changes write-protect at least one quarter period before the SCL rise it is meant to hit. This keeps the write-protect level stable across the synchroniser when the D0 edge is sampled.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;
  typedef enum logic [2:0] {
    PS_IDLE, PS_DEV, PS_WADDR, PS_WDATA, PS_RDATA, PS_RACK
  } proto_st_e;

  typedef enum logic [1:0] {
    WS_IDLE, WS_LOAD, WS_ARMED, WS_BUSY
  } wctl_st_e;

  localparam logic [7:0] CORRUPT_BYTE = 8'hFF;
endpackage

// File: rtl/i2c_ee_sync.sv
module i2c_ee_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wp_i,
  output logic scl_o,
  output logic sda_o,
  output logic wp_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff, wp_ff;
  logic              scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      wp_ff  <= '0;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      wp_ff  <= {wp_ff[STAGES-2:0], wp_i};
      scl_d  <= scl_ff[STAGES-1];
      sda_d  <= sda_ff[STAGES-1];
    end
  end

  assign scl_o      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign wp_o       = wp_ff[STAGES-1];
  assign scl_rise_o = ~scl_d & scl_o;
  assign scl_fall_o = scl_d & ~scl_o;
  // SDA edges while SCL stays high frame a transfer
  assign start_o    = scl_d & scl_o & sda_d & ~sda_o;
  assign stop_o     = scl_d & scl_o & ~sda_d & sda_o;
endmodule

// File: rtl/i2c_ee_proto.sv
module i2c_ee_proto
  import i2c_ee_pkg::*;
#(
  parameter int         ADDR_W   = 8,
  parameter int         PAGE_W   = 3,
  parameter logic [6:0] DEV_ADDR = 7'h50
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              sda_i,
  input  logic              wp_i,
  input  logic              busy_i,
  input  logic              cancel_i,
  input  logic [7:0]        rd_data_i,
  output logic              sda_oe_o,
  output logic              waddr_o,
  output logic              wbyte_o,
  output logic [7:0]        wbyte_data_o,
  output logic [PAGE_W-1:0] wbyte_off_o,
  output logic              wbyte_wp_o,
  output logic [ADDR_W-1:0] ptr_o
);
  proto_st_e         st_q, nxt_q;
  logic [3:0]        bit_q;
  logic [6:0]        sh_q;
  logic [7:0]        tx_q;
  logic              oe_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [7:0]        byte_in;

  assign byte_in = {sh_q, sda_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= PS_IDLE;
      nxt_q        <= PS_IDLE;
      bit_q        <= '0;
      sh_q         <= '0;
      tx_q         <= '0;
      oe_q         <= 1'b0;
      ptr_q        <= '0;
      waddr_o      <= 1'b0;
      wbyte_o      <= 1'b0;
      wbyte_data_o <= '0;
      wbyte_off_o  <= '0;
      wbyte_wp_o   <= 1'b0;
    end else begin
      waddr_o <= 1'b0;
      wbyte_o <= 1'b0;
      if (start_i) begin
        st_q  <= PS_DEV;
        bit_q <= '0;
        oe_q  <= 1'b0;
      end else if (stop_i || cancel_i) begin
        st_q <= PS_IDLE;
        oe_q <= 1'b0;
      end else begin
        case (st_q)
          PS_DEV, PS_WADDR, PS_WDATA: begin
            if (scl_rise_i && bit_q < 4'd8) begin
              sh_q  <= byte_in[6:0];
              bit_q <= bit_q + 4'd1;
              if (bit_q == 4'd7) begin
                case (st_q)
                  PS_DEV: begin
                    if (byte_in[7:1] == DEV_ADDR && !busy_i) begin
                      nxt_q <= byte_in[0] ? PS_RDATA : PS_WADDR;
                      tx_q  <= rd_data_i;
                    end else begin
                      st_q <= PS_IDLE;
                    end
                  end
                  PS_WADDR: begin
                    ptr_q   <= byte_in[ADDR_W-1:0];
                    waddr_o <= 1'b1;
                    nxt_q   <= PS_WDATA;
                  end
                  default: begin
                    // D0 latch edge: capture write-protect with the byte
                    wbyte_o      <= 1'b1;
                    wbyte_data_o <= byte_in;
                    wbyte_off_o  <= ptr_q[PAGE_W-1:0];
                    wbyte_wp_o   <= wp_i;
                    ptr_q        <= {ptr_q[ADDR_W-1:PAGE_W], ptr_q[PAGE_W-1:0] + 1'b1};
                    nxt_q        <= PS_WDATA;
                  end
                endcase
              end
            end else if (scl_fall_i && bit_q == 4'd8) begin
              oe_q  <= 1'b1;
              bit_q <= 4'd9;
            end else if (scl_fall_i && bit_q == 4'd9) begin
              bit_q <= '0;
              st_q  <= nxt_q;
              oe_q  <= (nxt_q == PS_RDATA) ? ~tx_q[7] : 1'b0;
            end
          end
          PS_RDATA: begin
            if (scl_rise_i) begin
              bit_q <= bit_q + 4'd1;
            end else if (scl_fall_i) begin
              if (bit_q == 4'd8) begin
                oe_q  <= 1'b0;
                bit_q <= '0;
                st_q  <= PS_RACK;
                ptr_q <= ptr_q + 1'b1;
              end else begin
                tx_q <= {tx_q[6:0], 1'b0};
                oe_q <= ~tx_q[6];
              end
            end
          end
          PS_RACK: if (scl_rise_i) st_q <= PS_IDLE;
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o = oe_q;
  assign ptr_o    = ptr_q;

  AST_NO_ACK_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == PS_DEV && oe_q) |-> !busy_i); // R5
  AST_CANCEL_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cancel_i |=> !oe_q); // R9
  AST_PAGE_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wbyte_o |-> ptr_q[ADDR_W-1:PAGE_W] == $past(ptr_q[ADDR_W-1:PAGE_W])); // R4
endmodule

// File: rtl/i2c_ee_store.sv
module i2c_ee_store
  import i2c_ee_pkg::*;
#(
  parameter int DEPTH     = 256,
  parameter int PAGE      = 8,
  parameter int WR_CYCLES = 500000,
  localparam int AW  = $clog2(DEPTH),
  localparam int PW  = $clog2(PAGE),
  localparam int WCW = $clog2(WR_CYCLES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          waddr_i,
  input  logic [AW-1:0] ptr_i,
  input  logic          wbyte_i,
  input  logic [7:0]    wbyte_data_i,
  input  logic [PW-1:0] wbyte_off_i,
  input  logic          wbyte_wp_i,
  input  logic          wp_i,
  input  logic          start_i,
  input  logic          stop_i,
  output logic          busy_o,
  output logic          cancel_o,
  output logic [7:0]    rd_data_o
);
  wctl_st_e         st_q;
  logic [7:0]       mem_q [DEPTH];
  logic [7:0]       buf_q [PAGE];
  logic [PAGE-1:0]  vld_q;
  logic [AW-PW-1:0] page_q;
  logic [WCW-1:0]   wcnt_q;
  logic             load_cancel, armed_cancel, busy_cancel, cyc_done;

  assign load_cancel  = (st_q == WS_LOAD) && wbyte_i && wbyte_wp_i;
  assign armed_cancel = (st_q == WS_ARMED) && wp_i;
  assign busy_cancel  = (st_q == WS_BUSY) && wp_i;
  assign cancel_o     = load_cancel | armed_cancel | busy_cancel;
  assign cyc_done     = (st_q == WS_BUSY) && (wcnt_q == WCW'(WR_CYCLES - 1));
  assign busy_o       = (st_q == WS_BUSY);
  assign rd_data_o    = mem_q[ptr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= WS_IDLE;
      vld_q  <= '0;
      page_q <= '0;
      wcnt_q <= '0;
      for (int i = 0; i < PAGE; i++) buf_q[i] <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      case (st_q)
        WS_IDLE: if (waddr_i) begin
          st_q   <= WS_LOAD;
          vld_q  <= '0;
          page_q <= ptr_i[AW-1:PW];
        end
        WS_LOAD: begin
          if (start_i || stop_i) begin
            st_q <= WS_IDLE;
          end else if (wbyte_i) begin
            if (wbyte_wp_i) begin
              st_q <= WS_IDLE;
            end else begin
              buf_q[wbyte_off_i] <= wbyte_data_i;
              vld_q[wbyte_off_i] <= 1'b1;
              st_q               <= WS_ARMED;
            end
          end
        end
        WS_ARMED: begin
          if (wp_i) begin
            st_q  <= WS_IDLE;
            vld_q <= '0;
          end else if (stop_i) begin
            st_q   <= WS_BUSY;
            wcnt_q <= '0;
          end else if (start_i) begin
            st_q <= WS_IDLE;
          end else if (wbyte_i) begin
            buf_q[wbyte_off_i] <= wbyte_data_i;
            vld_q[wbyte_off_i] <= 1'b1;
          end
        end
        default: begin
          if (busy_cancel || cyc_done) begin
            st_q <= WS_IDLE;
            for (int i = 0; i < PAGE; i++)
              if (vld_q[i]) mem_q[{page_q, PW'(i)}] <= busy_cancel ? CORRUPT_BYTE : buf_q[i];
          end else begin
            wcnt_q <= wcnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  AST_LOAD_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == WS_LOAD && !wbyte_i && !start_i && !stop_i) |=> st_q == WS_LOAD); // R6
  AST_CANCEL_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cancel_o |=> (st_q == WS_IDLE && !busy_o)); // R8
  AST_BUSY_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> ($past(wcnt_q) == WCW'(WR_CYCLES - 1) || $past(wp_i))); // R5
endmodule

// File: rtl/i2c_eeprom_wp.sv
module i2c_eeprom_wp #(
  parameter int         MEM_DEPTH   = 256,
  parameter int         PAGE_SIZE   = 8,
  parameter int         WR_CYCLES   = 500000,
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o,
  input  logic wp_i
);
  localparam int AW = $clog2(MEM_DEPTH);
  localparam int PW = $clog2(PAGE_SIZE);

  logic          scl_s, sda_s, wp_s, scl_rise, scl_fall, start_p, stop_p;
  logic          waddr, wbyte, wbyte_wp, busy, cancel;
  logic [7:0]    wbyte_data, rd_data;
  logic [PW-1:0] wbyte_off;
  logic [AW-1:0] ptr;

  i2c_ee_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i, .wp_i,
    .scl_o(scl_s), .sda_o(sda_s), .wp_o(wp_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_p), .stop_o(stop_p)
  );

  i2c_ee_proto #(.ADDR_W(AW), .PAGE_W(PW), .DEV_ADDR(DEV_ADDR)) u_proto (
    .clk_i, .rst_ni,
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_p), .stop_i(stop_p),
    .sda_i(sda_s), .wp_i(wp_s),
    .busy_i(busy), .cancel_i(cancel), .rd_data_i(rd_data),
    .sda_oe_o, .waddr_o(waddr), .wbyte_o(wbyte),
    .wbyte_data_o(wbyte_data), .wbyte_off_o(wbyte_off),
    .wbyte_wp_o(wbyte_wp), .ptr_o(ptr)
  );

  i2c_ee_store #(.DEPTH(MEM_DEPTH), .PAGE(PAGE_SIZE), .WR_CYCLES(WR_CYCLES)) u_store (
    .clk_i, .rst_ni,
    .waddr_i(waddr), .ptr_i(ptr),
    .wbyte_i(wbyte), .wbyte_data_i(wbyte_data),
    .wbyte_off_i(wbyte_off), .wbyte_wp_i(wbyte_wp),
    .wp_i(wp_s), .start_i(start_p), .stop_i(stop_p),
    .busy_o(busy), .cancel_o(cancel), .rd_data_o(rd_data)
  );

  logic scl_unused;
  assign scl_unused = scl_s;
endmodule

// File: tb/i2c_eeprom_wp_bench.sv
module i2c_eeprom_wp_bench;
  localparam int DEPTH = 256;
  localparam int PAGE  = 8;
  localparam int WRC   = 600;
  localparam int Q     = 4;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, hsda = 1'b1, wp = 1'b0;
  logic sda_oe, sda;
  int   checks = 0, errors = 0;
  logic [7:0] mem_m [DEPTH];
  logic [7:0] wdat  [16];

  always #5 clk = ~clk;
  assign sda = hsda & ~sda_oe;

  i2c_eeprom_wp #(.MEM_DEPTH(DEPTH), .PAGE_SIZE(PAGE), .WR_CYCLES(WRC)) u_i2c_eeprom_wp (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda), .sda_oe_o(sda_oe), .wp_i(wp)
  );

  function automatic logic [7:0] page_next(logic [7:0] a);
    return {a[7:3], a[2:0] + 3'd1};
  endfunction

  task automatic tick(int n); repeat (n) @(posedge clk); #1; endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic i2c_start;
    hsda = 1'b1; tick(Q); scl = 1'b1; tick(Q); hsda = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop;
    hsda = 1'b0; tick(Q); scl = 1'b1; tick(Q); hsda = 1'b1; tick(Q);
  endtask

  task automatic put_byte(input logic [7:0] b, input int wp_bit, input logic wp_val, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      if ((7 - i) == wp_bit) wp = wp_val;
      hsda = b[i]; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
    end
    hsda = 1'b1; tick(Q); scl = 1'b1; tick(Q); ack = ~sda; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic get_byte(output logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      hsda = 1'b1; tick(Q); scl = 1'b1; tick(Q); b = {b[6:0], sda}; tick(Q); scl = 1'b0; tick(Q);
    end
    hsda = 1'b1; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
  endtask

  task automatic addr_only(input logic [7:0] dev, output logic ack);
    i2c_start; put_byte(dev, -1, 1'b0, ack); i2c_stop;
  endtask

  task automatic write_tx(input logic [7:0] addr, input int n, input int wp_byte,
                          input int wp_bit, output int acked);
    logic ack;
    acked = 0;
    i2c_start;
    put_byte(8'hA0, -1, 1'b0, ack);
    if (ack) begin
      put_byte(addr, -1, 1'b0, ack);
      for (int j = 0; j < n; j++) begin
        put_byte(wdat[j], (j == wp_byte) ? wp_bit : -1, 1'b1, ack);
        if (!ack) break;
        acked++;
      end
    end
    i2c_stop;
  endtask

  task automatic read_rand(input logic [7:0] addr, output logic [7:0] d);
    logic ack;
    i2c_start; put_byte(8'hA0, -1, 1'b0, ack); put_byte(addr, -1, 1'b0, ack);
    i2c_start; put_byte(8'hA1, -1, 1'b0, ack); get_byte(d); i2c_stop;
  endtask

  task automatic read_cur(output logic [7:0] d);
    logic ack;
    i2c_start; put_byte(8'hA1, -1, 1'b0, ack); get_byte(d); i2c_stop;
  endtask

  task automatic wait_ready(output int polls);
    logic ack;
    polls = 0;
    do begin addr_only(8'hA0, ack); polls++; end while (!ack && polls < 50);
  endtask

  task automatic model_write(input logic [7:0] addr, input int n);
    logic [7:0] a = addr;
    for (int j = 0; j < n; j++) begin mem_m[a] = wdat[j]; a = page_next(a); end
  endtask

  task automatic chk_loc(string tag, input logic [7:0] addr);
    logic [7:0] d;
    read_rand(addr, d);
    chk(tag, {24'd0, d}, {24'd0, mem_m[addr]});
  endtask

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run;
  end

  initial begin
    logic ack;
    logic [7:0] d;
    int polls, acked;
    void'($urandom(32'd4711));
    for (int i = 0; i < DEPTH; i++) mem_m[i] = 8'h00;
    tick(5); rst_n = 1'b1; tick(5);

    chk("R1 sda released", {31'd0, sda_oe}, 32'd0);
    chk_loc("R1 reset content", 8'h10);

    addr_only(8'hA2, ack); chk("R2 foreign address nacked", {31'd0, ack}, 32'd0);
    addr_only(8'hA0, ack); chk("R2 own address acked", {31'd0, ack}, 32'd1);

    wdat[0] = 8'hA5;
    write_tx(8'h05, 1, -1, -1, acked); model_write(8'h05, 1);
    chk("R3 data byte acked", acked, 1);
    wait_ready(polls);
    chk("R5 busy nacks poll", {31'd0, polls >= 2}, 32'd1);
    chk("R5 ready after cycle", {31'd0, polls < 50}, 32'd1);
    chk_loc("R3 byte stored", 8'h05);

    for (int j = 0; j < 10; j++) wdat[j] = 8'hC0 + 8'(j);
    write_tx(8'h1E, 10, -1, -1, acked); model_write(8'h1E, 10);
    chk("R4 page bytes acked", acked, 10);
    wait_ready(polls);
    for (int a = 8'h18; a <= 8'h1F; a++) chk_loc("R4 wrapped page", 8'(a));
    chk_loc("R4 next page untouched", 8'h20);

    for (int it = 0; it < 12; it++) begin
      logic [7:0] a = 8'($urandom);
      int n = 1 + int'($urandom % PAGE);
      for (int j = 0; j < n; j++) wdat[j] = 8'($urandom);
      write_tx(a, n, -1, -1, acked); model_write(a, n);
      wait_ready(polls);
      chk_loc("R3 random first byte", a);
      chk_loc("R4 random in page", {a[7:3], 3'($urandom)});
    end

    wp = 1'b1;
    i2c_start;
    put_byte(8'hA0, -1, 1'b0, ack);
    put_byte(8'h70, 4, 1'b0, ack);
    put_byte(8'h3C, -1, 1'b0, ack);
    i2c_stop;
    chk("R6 data acked despite early WP", {31'd0, ack}, 32'd1);
    mem_m[8'h70] = 8'h3C;
    wait_ready(polls);
    chk("R6 write cycle ran", {31'd0, polls >= 2}, 32'd1);
    chk_loc("R6 byte stored", 8'h70);

    wdat[0] = 8'h77;
    write_tx(8'h40, 1, 0, 7, acked); wp = 1'b0;
    chk("R7 byte nacked", acked, 0);
    addr_only(8'hA0, ack); chk("R7 no write wait", {31'd0, ack}, 32'd1);
    chk_loc("R7 location unchanged", 8'h40);

    for (int j = 0; j < 4; j++) wdat[j] = 8'h90 + 8'(j);
    write_tx(8'h48, 4, 1, 2, acked); wp = 1'b0;
    chk("R8 only first byte acked", acked, 1);
    addr_only(8'hA0, ack); chk("R8 no write wait", {31'd0, ack}, 32'd1);
    chk_loc("R8 first unchanged", 8'h48);
    chk_loc("R8 second unchanged", 8'h49);

    wdat[0] = 8'hAA; wdat[1] = 8'hBB; wdat[2] = 8'hCC;
    write_tx(8'h50, 3, -1, -1, acked);
    chk("R9 bytes acked", acked, 3);
    tick(60); wp = 1'b1; tick(8); wp = 1'b0;
    for (int j = 0; j < 3; j++) mem_m[8'h50 + j] = 8'hFF;
    addr_only(8'hA0, ack); chk("R9 acked at once", {31'd0, ack}, 32'd1);
    chk_loc("R9 corrupt 0", 8'h50);
    chk_loc("R9 corrupt 1", 8'h51);
    chk_loc("R9 corrupt 2", 8'h52);

    read_rand(8'h1A, d); chk("R10 random read", {24'd0, d}, {24'd0, mem_m[8'h1A]});
    read_cur(d);         chk("R10 current read", {24'd0, d}, {24'd0, mem_m[8'h1B]});
    read_rand(8'hFF, d); chk("R10 top read", {24'd0, d}, {24'd0, mem_m[8'hFF]});
    read_cur(d);         chk("R10 pointer wraps", {24'd0, d}, {24'd0, mem_m[8'h00]});

    i2c_start; put_byte(8'hA0, -1, 1'b0, ack); put_byte(8'h60, -1, 1'b0, ack); i2c_stop;
    addr_only(8'hA0, ack); chk("R11 no cycle after empty write", {31'd0, ack}, 32'd1);
    chk_loc("R11 location unchanged", 8'h60);

    finish_run;
  end
endmodule